// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns a parallel word into a serial bit stream through two storage stages. A holding latch takes a snapshot of the parallel inputs whenever the capture strobe pulses. A shift register behind it is controlled by a mode input. With mode low, the register copies the holding latch on every clock. With mode high, the register shifts one place toward its most significant stage on each shift strobe and takes the serial input into stage 0. The most significant stage drives the serial output at all times.

Both strobes are single-cycle enables sampled on the one system clock. If they come from external pins, they must first pass through a synchronizer and edge detector outside this block. The active-low reset clears only the shift register, so a word captured before a reset can still be loaded and sent afterwards. Reset asserts asynchronously. Its release is synchronized inside the block, and the register stays clear for the first two clock edges after release.

Top module: `latched_piso`

## Requirements
- R1: A clock edge with `cap_pulse` high stores `par_in` into the holding latch.
- R2: The holding latch keeps its value on every edge with `cap_pulse` low. This is observed by loading the latch into the register and shifting it out.
- R3: On every edge with `ser_mode` low (load mode), the register takes the holding latch value as it stood before that edge, whatever `shift_pulse` is. A word captured on the same edge reaches the register on the next load edge.
- R4: On an edge with `ser_mode` high and `shift_pulse` high, bit 0 of the register takes `ser_in` and each bit n takes the old bit n-1.
- R5: `ser_out` always equals the register's most significant bit (stage WIDTH-1). Stage 0 is the stage that receives serial data.
- R6: While `rst_n` is low, and on the first two clock edges after it rises, the register is all zero and `ser_out` is 0. Reset assertion takes effect without waiting for a clock edge. The holding latch is not affected by reset.
- R7: `ser_in` has no effect on the register while `ser_mode` is low.
- R8: When `cap_pulse` and `shift_pulse` are both high with `ser_mode` high, the latch captures `par_in` and the register shifts on the same edge.
- R9: With `ser_mode` high and `shift_pulse` low, the register holds its value, even if `cap_pulse` loads the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low reset of the shift register; asserts asynchronously, released synchronously |
| par_in | input | WIDTH | Parallel data word for the holding latch |
| cap_pulse | input | 1 | Single-cycle capture enable for the holding latch |
| ser_mode | input | 1 | 0: copy the latch into the register; 1: serial shifting allowed |
| shift_pulse | input | 1 | Single-cycle shift enable, used only when `ser_mode` is 1 |
| ser_in | input | 1 | Serial data shifted into stage 0 |
| ser_out | output | 1 | Most significant register stage |

## Verification
Only one bit of the register is visible at the port. A wrong stage inside the register therefore shows up only when shifting carries that stage to the output, which can take up to WIDTH shift strobes. A corrupted holding latch shows up only after a load followed by a full shift-out. For this reason the bench repeatedly loads a word and shifts it all the way out, including after a reset, to expose latch and register faults. A behavioural model compares `ser_out` against its expected value every cycle, so a wrong load, hold or shift is reported in the first cycle it reaches the output.

// File: rtl/latched_piso.sv
module latched_piso #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_pulse,
  input  logic             ser_mode,
  input  logic             shift_pulse,
  input  logic             ser_in,
  output logic             ser_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] sreg_q;
  logic [1:0]       rst_sync;
  logic             run;

  assign run     = rst_sync[1];
  assign ser_out = sreg_q[MSB];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};

  always_ff @(posedge clk)
    if (cap_pulse) hold_q <= par_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            sreg_q <= '0;
    else if (!run)         sreg_q <= '0;
    else if (!ser_mode)    sreg_q <= hold_q;
    else if (shift_pulse)  sreg_q <= {sreg_q[MSB-1:0], ser_in};

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> hold_q == $past(par_in));

  p_latch_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse |=> $stable(hold_q));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ser_mode) |=> sreg_q == $past(hold_q));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ser_mode && shift_pulse) |=> sreg_q == {$past(sreg_q[MSB-1:0]), $past(ser_in)});

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sreg_q == '0);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ser_mode && !shift_pulse) |=> $stable(sreg_q));

endmodule

// File: tb/test_latched_piso.sv
module test_latched_piso;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] par_in;
  logic         cap_pulse, ser_mode, shift_pulse, ser_in;
  logic         ser_out;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_hold = '0;
  logic [W-1:0] m_sreg = '0;
  int           m_rel  = 0;

  always #2 clk = ~clk;

  latched_piso #(.WIDTH(W)) i_latched_piso (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_pulse(cap_pulse),
    .ser_mode(ser_mode), .shift_pulse(shift_pulse), .ser_in(ser_in),
    .ser_out(ser_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sreg = '0;
      m_rel  = 0;
    end else begin
      if (m_rel < 2) begin
        m_sreg = '0;
        m_rel++;
      end else if (!ser_mode) m_sreg = m_hold;
      else if (shift_pulse)   m_sreg = {m_sreg[W-2:0], ser_in};
    end
    if (clk && cap_pulse) m_hold = par_in;
  end

  task automatic check(string tag);
    checks++;
    if (ser_out !== m_sreg[W-1]) begin
      fails++;
      $display("FAIL %s: ser_out=%b expected=%b at %0t", tag, ser_out, m_sreg[W-1], $time);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic drive(logic c, logic [W-1:0] p, logic m, logic s, logic d);
    cap_pulse = c; par_in = p; ser_mode = m; shift_pulse = s; ser_in = d;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 8'h3C, 1'b1, 1'b0, 1'b0);
    #1 check("R6");
    tick("R1");
    tick("R6");
    rst_n = 1'b1;
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    tick("R6");
    tick("R6");
    tick("R3");

    drive(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
    tick("R1");
    drive(1'b0, 8'hFF, 1'b0, 1'b1, 1'b1);
    tick("R3");
    tick("R2");
    for (int i = 0; i < W + 2; i++) begin
      drive(1'b0, 8'hFF, 1'b1, 1'b1, i[0]);
      tick("R4");
      check("R5");
    end

    drive(1'b1, 8'h81, 1'b0, 1'b0, 1'b0);
    tick("R3");
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 8'h00, 1'b0, 1'b1, i[0]);
      tick("R7");
    end
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 8'h0F ^ 8'(i), 1'b1, 1'b0, 1'b1);
      tick("R9");
    end
    for (int i = 0; i < W; i++) begin
      drive(1'b1, 8'(i * 37), 1'b1, 1'b1, ~i[1]);
      tick("R8");
    end
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    tick("R8");
    for (int i = 0; i < W; i++) begin
      drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
      tick("R8");
    end

    drive(1'b1, 8'h96, 1'b0, 1'b0, 1'b0);
    tick("R1");
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    tick("R3");
    rst_n = 1'b0;
    #1 check("R6");
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    tick("R6");
    rst_n = 1'b1;
    tick("R6");
    tick("R6");
    tick("R6");
    for (int i = 0; i < W; i++) begin
      drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
      tick("R6");
    end

    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom), 8'($urandom), 1'($urandom_range(0, 3) != 0),
            1'($urandom), 1'($urandom));
      tick("R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule